// File: doc/BRIEF.md
# I2C Master Control and Event Register Unit

This unit is the register front end of an I2C master. Software reaches it over a small byte-wide register bus. It holds the enable, the own-address and baud settings, and the command bits that start a transfer and select master operation. The transfer engine reports what happens on the wire with single-cycle pulses. The unit latches those pulses into a sticky event register, and software acknowledges events by writing ones back. A mask register selects which pending events drive the single interrupt line.

A transfer starts when software writes the start bit. The start request stays raised toward the engine until the engine accepts it, and then it clears by itself. When the engine sees a bus collision, the unit drops the master bit. Software has to set that bit again before it retries.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset every register reads as zero, and `ctl_enable`, `ctl_master`, `ctl_start` and `irq` are low.
- R2: The mode register at offset 0 keeps only bit 0, which drives `ctl_enable`. Bits 7..1 read as zero.
- R3: The address register at offset 4 stores bits 7..1 and drives them on `own_addr`, with bit 0 reading as zero. The baud register at offset 8 stores all 8 bits and drives `baud_div`.
- R4: In the command register at offset 12, writing a one to bit 7 raises `ctl_start` from the next cycle. It stays high until the clock edge at which `start_ack` is sampled high, and it is low from the following cycle. Writing a zero to bit 7 does not cancel a pending start. If a start write arrives in the same cycle as an acknowledge, a new request is raised. Bit 7 reads back the pending state.
- R5: Bit 0 of the command register is the master bit. It is readable and writable and drives `ctl_master`. An `evt_coll` pulse clears it, and the collision wins over a write in the same cycle.
- R6: The event register at offset 16 latches pulses as follows: bit 4 is transmit error (`evt_txerr`), bit 2 is bus busy (`evt_busy`), bit 1 is transmit done (`evt_txdone`) and bit 0 is receive done (`evt_rxdone`). Set bits stay set. Bits 7, 6, 5 and 3 read as zero.
- R7: Writing the event register clears each event bit written as one and leaves each bit written as zero unchanged. Writing 0xFF clears all events, and writing back a value just read clears exactly those events.
- R8: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: The mask register at offset 20 uses the event bit layout, and its unused bits read as zero. `irq` is high exactly while the AND of event and mask is nonzero, so a mask of zero keeps `irq` low.
- R10: Any other offset reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| evt_txdone | input | 1 | Pulse: transmit buffer done |
| evt_rxdone | input | 1 | Pulse: receive buffer done |
| evt_txerr | input | 1 | Pulse: transmit error |
| evt_busy | input | 1 | Pulse: bus busy |
| evt_coll | input | 1 | Pulse: bus collision |
| start_ack | input | 1 | Engine accepted the start request |
| ctl_enable | output | 1 | Controller enable |
| ctl_master | output | 1 | Master mode select |
| ctl_start | output | 1 | Pending start request |
| own_addr | output | 7 | Own slave address |
| baud_div | output | 8 | Baud divider setting |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the block into several corner cases and checks each one:
- An event pulse in the same cycle as its clear. A design that let the clear win would lose that event silently.
- A write-back of a partial read value. A design that cleared too much would drop events that were still pending.
- A collision that coincides with a write setting the master bit. A wrong priority would leave `ctl_master` high after lost arbitration.
- A start write that lands on an acknowledge, and a zero written to the start bit. A faulty design would either lose the new request or cancel one that is still pending.
- Writes to unmapped offsets, and a mask of zero with events pending. These expose aliasing in the address decode and interrupt leakage.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int DW = 8;

  localparam int OFF_MODE = 0;
  localparam int OFF_ADDR = 4;
  localparam int OFF_BAUD = 8;
  localparam int OFF_CMD  = 12;
  localparam int OFF_EVT  = 16;
  localparam int OFF_MASK = 20;

  localparam int EVB_RX   = 0;
  localparam int EVB_TX   = 1;
  localparam int EVB_BUSY = 2;
  localparam int EVB_TERR = 4;

  localparam logic [DW-1:0] EV_USED =
    DW'((1 << EVB_RX) | (1 << EVB_TX) | (1 << EVB_BUSY) | (1 << EVB_TERR));

  localparam int CMDB_START  = 7;
  localparam int CMDB_MASTER = 0;
  localparam int MODEB_EN    = 0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_ADDR, SEL_BAUD, SEL_CMD, SEL_EVT, SEL_MASK
  } reg_sel_e;

  function automatic logic [DW-1:0] ev_pack(input logic terr, input logic busy,
                                            input logic txd, input logic rxd);
    logic [DW-1:0] v;
    v = '0;
    v[EVB_TERR] = terr;
    v[EVB_BUSY] = busy;
    v[EVB_TX]   = txd;
    v[EVB_RX]   = rxd;
    return v;
  endfunction

  function automatic logic ev_next_bit(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  function automatic logic irq_of(input logic [DW-1:0] ev, input logic [DW-1:0] msk);
    return |(ev & msk);
  endfunction
endpackage

// File: rtl/i2c_ctl_decode.sv
module i2c_ctl_decode
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    case (32'(addr_i))
      OFF_MODE: sel_o = SEL_MODE;
      OFF_ADDR: sel_o = SEL_ADDR;
      OFF_BAUD: sel_o = SEL_BAUD;
      OFF_CMD:  sel_o = SEL_CMD;
      OFF_EVT:  sel_o = SEL_EVT;
      OFF_MASK: sel_o = SEL_MASK;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/i2c_ctl_events.sv
module i2c_ctl_events
  import i2c_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] mask_wd_i,
  output logic [DW-1:0] ev_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] ev_q;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] set_eff;
  logic [DW-1:0] clr_only;

  assign set_eff  = set_i & EV_USED;
  assign clr_only = clr_i & ~set_i & EV_USED;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (EV_USED[i]) begin : g_used
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ev_q[i]   <= 1'b0;
          mask_q[i] <= 1'b0;
        end else begin
          ev_q[i] <= ev_next_bit(ev_q[i], clr_i[i], set_i[i]);
          if (mask_we_i) mask_q[i] <= mask_wd_i[i];
        end
      end
    end else begin : g_unused
      assign ev_q[i]   = 1'b0;
      assign mask_q[i] = 1'b0;
    end
  end

  assign ev_o   = ev_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_of(ev_q, mask_q);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((ev_q & $past(set_eff)) == $past(set_eff)));
  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_only) |=> ((ev_q & $past(clr_only)) == '0));
  // R9
  mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/i2c_ctl_cmd.sv
module i2c_ctl_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we_i,
  input  logic wd_start_i,
  input  logic wd_master_i,
  input  logic start_ack_i,
  input  logic coll_i,
  output logic start_o,
  output logic master_o
);
  logic start_q, master_q;
  logic start_set;

  assign start_set = cmd_we_i & wd_start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      master_q <= 1'b0;
    end else begin
      if (start_set)        start_q <= 1'b1;
      else if (start_ack_i) start_q <= 1'b0;
      if (coll_i)           master_q <= 1'b0;
      else if (cmd_we_i)    master_q <= wd_master_i;
    end
  end

  assign start_o  = start_q;
  assign master_o = master_q;

  // R4
  start_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && start_ack_i && !start_set) |=> !start_q);
  // R4
  start_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_set |=> start_q);
  // R5
  coll_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_i |=> !master_q);
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              evt_txdone,
  input  logic              evt_rxdone,
  input  logic              evt_txerr,
  input  logic              evt_busy,
  input  logic              evt_coll,
  input  logic              start_ack,
  output logic              ctl_enable,
  output logic              ctl_master,
  output logic              ctl_start,
  output logic [6:0]        own_addr,
  output logic [7:0]        baud_div,
  output logic              irq
);
  reg_sel_e      sel;
  logic          en_q;
  logic [6:0]    addr_q;
  logic [7:0]    baud_q;
  logic [DW-1:0] ev_set, ev_clr, ev_val, mask_val;
  logic          we_cmd, we_evt, we_mask;

  i2c_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(bus_addr), .sel_o(sel));

  assign we_cmd  = bus_wr && (sel == SEL_CMD);
  assign we_evt  = bus_wr && (sel == SEL_EVT);
  assign we_mask = bus_wr && (sel == SEL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_MODE) en_q   <= bus_wdata[MODEB_EN];
      if (sel == SEL_ADDR) addr_q <= bus_wdata[7:1];
      if (sel == SEL_BAUD) baud_q <= bus_wdata;
    end
  end

  assign ev_set = ev_pack(evt_txerr, evt_busy, evt_txdone, evt_rxdone);
  assign ev_clr = we_evt ? bus_wdata : '0;

  i2c_ctl_events u_ev (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(ev_clr),
    .mask_we_i(we_mask), .mask_wd_i(bus_wdata),
    .ev_o(ev_val), .mask_o(mask_val), .irq_o(irq)
  );

  i2c_ctl_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we_i(we_cmd),
    .wd_start_i(bus_wdata[CMDB_START]), .wd_master_i(bus_wdata[CMDB_MASTER]),
    .start_ack_i(start_ack), .coll_i(evt_coll),
    .start_o(ctl_start), .master_o(ctl_master)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_MODE: bus_rdata[MODEB_EN] = en_q;
      SEL_ADDR: bus_rdata = {addr_q, 1'b0};
      SEL_BAUD: bus_rdata = baud_q;
      SEL_CMD: begin
        bus_rdata[CMDB_START]  = ctl_start;
        bus_rdata[CMDB_MASTER] = ctl_master;
      end
      SEL_EVT:  bus_rdata = ev_val;
      SEL_MASK: bus_rdata = mask_val;
      default:  bus_rdata = '0;
    endcase
  end

  assign ctl_enable = en_q;
  assign own_addr   = addr_q;
  assign baud_div   = baud_q;

  // R10
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == 8'h00));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel == SEL_MODE) |=> $stable(ctl_enable));
endmodule

// File: tb/tb_i2c_ctl_regs.sv
module tb_i2c_ctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic evt_txdone = 0, evt_rxdone = 0, evt_txerr = 0, evt_busy = 0, evt_coll = 0;
  logic start_ack = 0;
  logic ctl_enable, ctl_master, ctl_start, irq;
  logic [6:0] own_addr;
  logic [7:0] baud_div;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic m_en, m_master, m_start;
  logic [7:0] m_addr, m_baud, m_ev, m_mask;

  always #5 clk = ~clk;

  i2c_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_txdone(evt_txdone), .evt_rxdone(evt_rxdone), .evt_txerr(evt_txerr),
    .evt_busy(evt_busy), .evt_coll(evt_coll), .start_ack(start_ack),
    .ctl_enable(ctl_enable), .ctl_master(ctl_master), .ctl_start(ctl_start),
    .own_addr(own_addr), .baud_div(baud_div), .irq(irq)
  );

  function automatic logic [7:0] pulses_to_bits(input logic [3:0] p);
    // p = {txerr, busy, txdone, rxdone} -> bits 4,2,1,0
    return {3'b000, p[3], 1'b0, p[2], p[1], p[0]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    case (a)
      5'd0:  return {7'd0, m_en};
      5'd4:  return {m_addr[7:1], 1'b0};
      5'd8:  return m_baud;
      5'd12: return {m_start, 6'd0, m_master};
      5'd16: return m_ev;
      5'd20: return m_mask;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    for (int i = 0; i < 8; i++) if (m_ev[i] && m_mask[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk("R2 ctl_enable", {7'd0, ctl_enable}, {7'd0, m_en});
    chk("R3 own_addr", {1'b0, own_addr}, {1'b0, m_addr[7:1]});
    chk("R3 baud_div", baud_div, m_baud);
    chk("R4 ctl_start", {7'd0, ctl_start}, {7'd0, m_start});
    chk("R5 ctl_master", {7'd0, ctl_master}, {7'd0, m_master});
    chk("R9 irq", {7'd0, irq}, {7'd0, exp_irq()});
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic step(input logic wr, input logic [4:0] a, input logic [7:0] d,
                      input logic [3:0] p, input logic coll, input logic ack);
    logic [7:0] clr;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    {evt_txerr, evt_busy, evt_txdone, evt_rxdone} = p;
    evt_coll = coll; start_ack = ack;
    @(posedge clk);
    clr = (wr && a == 5'd16) ? d : 8'h00;
    m_ev = ((m_ev & ~clr) | pulses_to_bits(p)) & 8'h17;
    if (wr && a == 5'd20) m_mask = d & 8'h17;
    if (wr && a == 5'd0) m_en = d[0];
    if (wr && a == 5'd4) m_addr = d & 8'hFE;
    if (wr && a == 5'd8) m_baud = d;
    if (wr && a == 5'd12 && d[7]) m_start = 1'b1;
    else if (ack) m_start = 1'b0;
    if (coll) m_master = 1'b0;
    else if (wr && a == 5'd12) m_master = d[0];
    @(negedge clk);
    bus_wr = 0; evt_txerr = 0; evt_busy = 0; evt_txdone = 0; evt_rxdone = 0;
    evt_coll = 0; start_ack = 0;
    check_outputs();
  endtask

  task automatic idle();
    step(1'b0, 5'd0, 8'h00, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic read_all(input string tag);
    rd_chk({tag, " mode"}, 5'd0);
    rd_chk({tag, " addr"}, 5'd4);
    rd_chk({tag, " baud"}, 5'd8);
    rd_chk({tag, " cmd"}, 5'd12);
    rd_chk({tag, " evt"}, 5'd16);
    rd_chk({tag, " mask"}, 5'd20);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_master = 0; m_start = 0;
    m_addr = 0; m_baud = 0; m_ev = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_outputs();
    read_all("R1 reset");

    // R2 mode: upper bits dropped
    step(1'b1, 5'd0, 8'hFF, 4'h0, 1'b0, 1'b0);
    rd_chk("R2 mode readback", 5'd0);
    // R3 address and baud
    step(1'b1, 5'd4, 8'hA5, 4'h0, 1'b0, 1'b0);
    step(1'b1, 5'd8, 8'h3C, 4'h0, 1'b0, 1'b0);
    rd_chk("R3 addr readback", 5'd4);
    rd_chk("R3 baud readback", 5'd8);

    // R6 event latching and unused bits
    step(1'b0, 5'd0, 8'h00, 4'hF, 1'b0, 1'b0);
    rd_chk("R6 all events set", 5'd16);
    // R9 mask zero keeps irq low, then enable one source
    chk("R9 irq with zero mask", {7'd0, irq}, 8'h00);
    step(1'b1, 5'd20, 8'hFF, 4'h0, 1'b0, 1'b0);
    rd_chk("R9 mask readback", 5'd20);
    // R7 write back a partial value clears only those bits
    step(1'b1, 5'd16, 8'h12, 4'h0, 1'b0, 1'b0);
    rd_chk("R7 partial clear", 5'd16);
    bus_addr = 5'd16; #1; snap = bus_rdata;
    step(1'b1, 5'd16, snap, 4'h0, 1'b0, 1'b0);
    rd_chk("R7 readback clear", 5'd16);
    // R8 set and clear on the same bit
    step(1'b0, 5'd0, 8'h00, 4'h3, 1'b0, 1'b0);
    step(1'b1, 5'd16, 8'hFF, 4'h1, 1'b0, 1'b0);
    rd_chk("R8 set wins over clear", 5'd16);
    step(1'b1, 5'd16, 8'hFF, 4'h0, 1'b0, 1'b0);
    rd_chk("R7 FF clears all", 5'd16);

    // R4 start one-shot
    step(1'b1, 5'd12, 8'h81, 4'h0, 1'b0, 1'b0);
    rd_chk("R4 start pending", 5'd12);
    step(1'b1, 5'd12, 8'h01, 4'h0, 1'b0, 1'b0);
    rd_chk("R4 zero does not cancel", 5'd12);
    idle();
    step(1'b0, 5'd0, 8'h00, 4'h0, 1'b0, 1'b1);
    rd_chk("R4 start cleared after ack", 5'd12);
    step(1'b1, 5'd12, 8'h81, 4'h0, 1'b0, 1'b1);
    rd_chk("R4 write beats ack", 5'd12);
    step(1'b0, 5'd0, 8'h00, 4'h0, 1'b0, 1'b1);
    // R5 collision drops master, wins over write
    step(1'b0, 5'd0, 8'h00, 4'h0, 1'b1, 1'b0);
    rd_chk("R5 master after collision", 5'd12);
    step(1'b1, 5'd12, 8'h01, 4'h0, 1'b1, 1'b0);
    rd_chk("R5 collision beats write", 5'd12);
    step(1'b1, 5'd12, 8'h01, 4'h0, 1'b0, 1'b0);
    rd_chk("R5 master set again", 5'd12);

    // R10 unmapped offsets
    step(1'b1, 5'd2, 8'hFF, 4'h0, 1'b0, 1'b0);
    step(1'b1, 5'd24, 8'hFF, 4'h0, 1'b0, 1'b0);
    step(1'b1, 5'd17, 8'hFF, 4'h0, 1'b0, 1'b0);
    rd_chk("R10 unmapped read 24", 5'd24);
    rd_chk("R10 unmapped read 13", 5'd13);
    read_all("R10 after unmapped writes");

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [4:0] a;
      logic [3:0] p;
      int r;
      r = $urandom_range(0, 7);
      a = (r < 6) ? 5'(r * 4) : 5'($urandom_range(0, 31));
      p = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      step($urandom_range(0, 1) == 1, a, 8'($urandom), p,
           $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0);
      rd_chk("R6 R7 R9 random readback", 5'($urandom_range(0, 31)));
    end
    read_all("R6 R7 final");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule